// File: doc/BRIEF.md
# Interval-Based DC Offset Remover

This block strips the DC component from one stream of signed samples. Every valid input sample has the contents of an offset register subtracted from it. The difference is clipped to the sample width and sent out one clock later with its own valid strobe. While samples stream through, the block also adds them up and counts them. At each end-of-interval pulse it takes the mean of that interval, which is the measured offset.

After each interval the offset register is updated, and a 9-bit blend coefficient sets how. The coefficient is an unsigned fraction in which 0x100 stands for 1.0:

- At 0 the register stays frozen. A value calibrated earlier, or written by the host, is kept indefinitely.
- At 0x100 the register is replaced by the new mean.
- At any other value the register moves that fraction of the way from its old content toward the mean. Values above 0x100 overshoot and saturate.

A host write port can load the register at any time. The write cancels an update that is still being computed. One instance serves one channel, so a current channel and a voltage channel each get their own instance and their own coefficient.

Top module: `dco_remover`

## Requirements
- R1: The corrected output equals the input sample minus the offset register, computed in signed two's complement and saturated to the signed SAMPLE_W range.
- R2: `corr_valid_o` is high exactly in the cycle after `smp_valid_i` was high. The sample uses the offset held in its own cycle, so a host write in that same cycle affects only later samples.
- R3: The measured offset is the signed sum of the interval's samples divided by their count, with the quotient truncated toward zero. A sample valid in the same cycle as `interval_end_i` belongs to the interval that is closing.
- R4: With coefficient 0, an interval end leaves the offset register unchanged.
- R5: With coefficient 0x100, the offset register becomes the measured offset.
- R6: For any other coefficient c (0 to 0x1FF), the new offset is old + floor(c*(measured-old)/256), saturated to the signed SAMPLE_W range.
- R7: An interval that holds no valid samples causes no update.
- R8: Within one interval, only the first 2^CNT_W-1 valid samples are accumulated. Later samples still pass through the correction path but do not enter the mean.
- R9: A host write sets the offset register, and the new value applies from the next sample on. The write discards any update whose interval closed in the same cycle or earlier and has not yet been applied.
- R10: An update completes within SAMPLE_W+CNT_W+3 cycles after its interval end. An interval that closes while an earlier update is still in progress produces no update.
- R11: After reset the offset register holds RST_OFFSET (0 by default) and `corr_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | SAMPLE_W | Raw signed sample |
| smp_valid_i | input | 1 | Sample strobe |
| interval_end_i | input | 1 | Closes the current accumulation interval |
| coef_i | input | 9 | Blend coefficient, 0x100 = 1.0 |
| host_wr_i | input | 1 | Host write strobe for the offset register |
| host_offset_i | input | SAMPLE_W | Signed value for a host write |
| corr_o | output | SAMPLE_W | Offset-corrected signed sample |
| corr_valid_o | output | 1 | Strobe for `corr_o` |

## Verification
The hardest situations to reach from the ports are races against an update that is still being computed. One is a host write that lands a few cycles after an interval end. The other is a second interval end that arrives while the division is still running. The stimulus places both events at fixed cycle offsets inside the division window, which lasts about SAMPLE_W+CNT_W cycles. It then reads the register back by sending a probe sample of -1. That value cannot saturate for any offset, so the register content is simply -1 minus the corrected output. A full sweep of all 512 coefficients, together with sample patterns whose sums are negative and not divisible by the count, covers the rounding and saturation corners of the blend.

// File: rtl/dco_pkg.sv
package dco_pkg;
  localparam int COEF_W = 9;
  localparam int FRAC_W = 8;

  typedef enum logic [1:0] {
    DIV_IDLE = 2'd0,
    DIV_RUN  = 2'd1,
    DIV_DONE = 2'd2
  } div_state_e;
endpackage

// File: rtl/dco_accum.sv
module dco_accum #(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 12,
  localparam int SUM_W   = SAMPLE_W + CNT_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic                       smp_valid_i,
  input  logic                       close_i,
  output logic signed [SUM_W-1:0]    snap_sum_o,
  output logic [CNT_W-1:0]           snap_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic signed [SUM_W-1:0] sum_q, sum_nx;
  logic [CNT_W-1:0]        cnt_q, cnt_nx;

  // samples past the count limit are dropped from the mean
  always_comb begin
    sum_nx = sum_q;
    cnt_nx = cnt_q;
    if (smp_valid_i && (cnt_q != CNT_MAX)) begin
      sum_nx = sum_q + SUM_W'(smp_i);
      cnt_nx = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q      <= '0;
      cnt_q      <= '0;
      snap_sum_o <= '0;
      snap_cnt_o <= '0;
    end else if (close_i) begin
      sum_q      <= '0;
      cnt_q      <= '0;
      snap_sum_o <= sum_nx;
      snap_cnt_o <= cnt_nx;
    end else begin
      sum_q <= sum_nx;
      cnt_q <= cnt_nx;
    end
  end
endmodule

// File: rtl/dco_divider.sv
module dco_divider import dco_pkg::*; #(
  parameter int NUM_W = 28,
  parameter int DEN_W = 12,
  parameter int OUT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [OUT_W-1:0] quo_o
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  div_state_e        state_q;
  logic [NUM_W-1:0]  quo_q;
  logic [DEN_W:0]    rem_q;
  logic [DEN_W-1:0]  den_q;
  logic [STEP_W-1:0] step_q;

  logic [DEN_W+1:0]  rem_sh, rem_sub;
  logic              fits;

  // one restoring step per cycle, MSB of the dividend first
  always_comb begin
    rem_sh  = {rem_q, quo_q[NUM_W-1]};
    fits    = rem_sh >= {2'b00, den_q};
    rem_sub = fits ? (rem_sh - {2'b00, den_q}) : rem_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DIV_IDLE;
      quo_q   <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        DIV_IDLE: if (start_i) begin
          quo_q   <= num_i;
          den_q   <= den_i;
          rem_q   <= '0;
          step_q  <= STEP_W'(NUM_W);
          state_q <= DIV_RUN;
        end
        DIV_RUN: begin
          quo_q  <= {quo_q[NUM_W-2:0], fits};
          rem_q  <= rem_sub[DEN_W:0];
          step_q <= step_q - 1'b1;
          if (step_q == STEP_W'(1)) state_q <= DIV_DONE;
        end
        DIV_DONE: state_q <= DIV_IDLE;
        default:  state_q <= DIV_IDLE;
      endcase
    end
  end

  assign busy_o = state_q != DIV_IDLE;
  assign done_o = state_q == DIV_DONE;
  assign quo_o  = quo_q[OUT_W-1:0];
endmodule

// File: rtl/dco_blend.sv
module dco_blend import dco_pkg::*; #(
  parameter int SAMPLE_W = 16
) (
  input  logic signed [SAMPLE_W-1:0] old_i,
  input  logic signed [SAMPLE_W:0]   meas_i,
  input  logic [COEF_W-1:0]          coef_i,
  output logic signed [SAMPLE_W-1:0] new_o
);
  localparam int DIFF_W = SAMPLE_W + 2;
  localparam int PROD_W = DIFF_W + COEF_W + 1;
  localparam int HI_W   = PROD_W - SAMPLE_W + 1;

  logic signed [DIFF_W-1:0] diff;
  logic signed [COEF_W:0]   coef_s;
  logic signed [PROD_W-1:0] prod, step, total;
  logic [HI_W-1:0]          hi;

  always_comb begin
    diff   = DIFF_W'(meas_i) - DIFF_W'(old_i);
    coef_s = $signed({1'b0, coef_i});
    prod   = PROD_W'(diff) * PROD_W'(coef_s);
    step   = prod >>> FRAC_W;
    total  = PROD_W'(old_i) + step;
    hi     = total[PROD_W-1:SAMPLE_W-1];
    // in range only when every bit above the sign bit matches it
    if ((&hi) || !(|hi)) new_o = total[SAMPLE_W-1:0];
    else if (total[PROD_W-1]) new_o = {1'b1, {(SAMPLE_W-1){1'b0}}};
    else new_o = {1'b0, {(SAMPLE_W-1){1'b1}}};
  end
endmodule

// File: rtl/dco_remover.sv
module dco_remover import dco_pkg::*; #(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 12,
  parameter logic signed [SAMPLE_W-1:0] RST_OFFSET = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic                       smp_valid_i,
  input  logic                       interval_end_i,
  input  logic [COEF_W-1:0]          coef_i,
  input  logic                       host_wr_i,
  input  logic signed [SAMPLE_W-1:0] host_offset_i,
  output logic signed [SAMPLE_W-1:0] corr_o,
  output logic                       corr_valid_o
);
  localparam int SUM_W = SAMPLE_W + CNT_W;
  localparam int MAG_W = SAMPLE_W + 1;

  logic signed [SUM_W-1:0]    snap_sum;
  logic [CNT_W-1:0]           snap_cnt;
  logic [SUM_W-1:0]           sum_mag;
  logic [MAG_W-1:0]           div_quo;
  logic signed [MAG_W-1:0]    meas;
  logic signed [SAMPLE_W-1:0] offset_q, blend_new;
  logic signed [SAMPLE_W:0]   raw_diff;
  logic accept, accept_q, start, div_busy, div_done;
  logic neg_q, discard_q, apply, in_flight;

  dco_accum #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) i_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_i       (smp_i),
    .smp_valid_i (smp_valid_i),
    .close_i     (interval_end_i),
    .snap_sum_o  (snap_sum),
    .snap_cnt_o  (snap_cnt)
  );

  // one update in flight at a time; later interval ends are dropped
  assign in_flight = accept_q | div_busy;
  assign accept    = interval_end_i & ~in_flight;
  assign start     = accept_q & (snap_cnt != '0);
  assign sum_mag   = snap_sum[SUM_W-1] ? -snap_sum : snap_sum;

  dco_divider #(.NUM_W(SUM_W), .DEN_W(CNT_W), .OUT_W(MAG_W)) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .num_i   (sum_mag),
    .den_i   (snap_cnt),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  assign meas = neg_q ? -$signed(div_quo) : $signed(div_quo);

  dco_blend #(.SAMPLE_W(SAMPLE_W)) i_blend (
    .old_i  (offset_q),
    .meas_i (meas),
    .coef_i (coef_i),
    .new_o  (blend_new)
  );

  assign apply = div_done & ~discard_q & ~host_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q  <= 1'b0;
      neg_q     <= 1'b0;
      discard_q <= 1'b0;
      offset_q  <= RST_OFFSET;
    end else begin
      accept_q <= accept;
      if (start) neg_q <= snap_sum[SUM_W-1];
      // host write cancels the update of any interval already closed
      if (accept) discard_q <= host_wr_i;
      else if (host_wr_i && in_flight) discard_q <= 1'b1;
      else if (div_done) discard_q <= 1'b0;
      if (host_wr_i) offset_q <= host_offset_i;
      else if (apply) offset_q <= blend_new;
    end
  end

  // correction path
  assign raw_diff = (SAMPLE_W+1)'(smp_i) - (SAMPLE_W+1)'(offset_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corr_o       <= '0;
      corr_valid_o <= 1'b0;
    end else begin
      corr_valid_o <= smp_valid_i;
      if (smp_valid_i) begin
        if (raw_diff[SAMPLE_W] == raw_diff[SAMPLE_W-1]) corr_o <= raw_diff[SAMPLE_W-1:0];
        else if (raw_diff[SAMPLE_W]) corr_o <= {1'b1, {(SAMPLE_W-1){1'b0}}};
        else corr_o <= {1'b0, {(SAMPLE_W-1){1'b1}}};
      end
    end
  end
endmodule

// File: rtl/dco_remover_chk.sv
module dco_remover_chk #(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 9
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                smp_valid_i,
  input logic                corr_valid_o,
  input logic                host_wr_i,
  input logic [SAMPLE_W-1:0] host_offset_i,
  input logic [COEF_W-1:0]   coef_i,
  input logic [SAMPLE_W-1:0] offset_q,
  input logic                apply,
  input logic [SAMPLE_W:0]   meas,
  input logic                accept_q,
  input logic                div_busy
);
  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> corr_valid_o);

  p_valid_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !corr_valid_o);

  p_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply && coef_i == '0) |=> $stable(offset_q));

  p_meas_fits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply |-> (meas[SAMPLE_W] == meas[SAMPLE_W-1]));

  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply && coef_i == COEF_W'(256)) |=> (offset_q == $past(meas[SAMPLE_W-1:0])));

  p_host_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i |=> (offset_q == $past(host_offset_i)));

  p_no_stray_update_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && !apply) |=> $stable(offset_q));

  p_single_job_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({accept_q, div_busy}));
endmodule

bind dco_remover dco_remover_chk #(.SAMPLE_W(SAMPLE_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .smp_valid_i   (smp_valid_i),
  .corr_valid_o  (corr_valid_o),
  .host_wr_i     (host_wr_i),
  .host_offset_i (host_offset_i),
  .coef_i        (coef_i),
  .offset_q      (offset_q),
  .apply         (apply),
  .meas          (meas),
  .accept_q      (accept_q),
  .div_busy      (div_busy)
);

// File: tb/test_dco_remover.sv
module test_dco_remover;
  localparam int W  = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic signed [W-1:0] smp, hv, corr;
  logic vld, ie, hw, cv;
  logic [8:0] coef;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dco_remover #(.SAMPLE_W(W), .CNT_W(CW)) i_dco_remover (
    .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .smp_valid_i(vld),
    .interval_end_i(ie), .coef_i(coef), .host_wr_i(hw),
    .host_offset_i(hv), .corr_o(corr), .corr_valid_o(cv)
  );

  function automatic int sat(input int x);
    if (x > 127) return 127;
    if (x < -128) return -128;
    return x;
  endfunction

  function automatic int blend(input int old, input int m, input int c);
    int p;
    p = c * (m - old);
    return sat(old + (p >>> 8));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int s, input bit v, input bit e, input bit w, input int h);
    smp = W'(s); vld = v; ie = e; hw = w; hv = W'(h);
    @(negedge clk);
    vld = 0; ie = 0; hw = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  // -1 minus any offset never saturates, so the offset is recoverable
  task automatic probe(output int off);
    cyc(-1, 1, 0, 0, 0);
    check("R2 probe valid", int'(cv), 1);
    off = -1 - int'(corr);
  endtask

  task automatic fresh(input int old);
    cyc(0, 0, 1, 0, 0);
    idle(40);
    cyc(0, 0, 0, 1, old);
  endtask

  int pat[$];

  // host value old, feed pat, close, wait, return register content
  task automatic run_iv(input int old, output int off);
    fresh(old);
    foreach (pat[i]) cyc(pat[i], 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    idle(40);
    probe(off);
  endtask

  function automatic int mean_of();
    int s = 0;
    int n = 0;
    foreach (pat[i]) if (n < 15) begin s += pat[i]; n++; end
    return s / n;
  endfunction

  function automatic string tag(input int c);
    if (c == 0) return "R4";
    if (c == 256) return "R5";
    return "R6";
  endfunction

  initial begin
    int off;
    int offs[6] = '{-128, -1, 0, 1, 127, 37};
    int coefs[10] = '{0, 1, 64, 128, 192, 255, 256, 257, 384, 511};
    rst_n = 0; smp = 0; vld = 0; ie = 0; hw = 0; hv = 0; coef = 9'h100;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R11 valid low after reset", int'(cv), 0);
    probe(off);
    check("R11 reset offset", off, 0);

    // R1 full sample sweep against several offsets
    foreach (offs[k]) begin
      cyc(0, 0, 0, 1, offs[k]);
      for (int s = -128; s < 128; s++) begin
        cyc(s, 1, 0, 0, 0);
        check("R1 corrected value", int'(corr), sat(s - offs[k]));
        check("R2 valid", int'(cv), 1);
      end
      idle(1);
      check("R2 valid after idle", int'(cv), 0);
    end

    // R2 write and sample in the same cycle
    cyc(0, 0, 0, 1, 3);
    cyc(10, 1, 0, 1, 5);
    check("R2 same-cycle write uses old offset", int'(corr), 7);
    probe(off);
    check("R2 write visible next sample", off, 5);

    // R6/R4/R5 full coefficient sweep
    pat = '{50, 50, 50, 50};
    for (int c = 0; c < 512; c++) begin
      coef = 9'(c);
      run_iv(-60, off);
      check(tag(c), off, blend(-60, 50, c));
    end

    // R3 rounding toward zero, R6 saturation with varied patterns
    for (int p = 0; p < 4; p++) begin
      int old;
      case (p)
        0: begin pat = '{-10, -10, -3}; old = 100; end
        1: begin pat = '{127, 127, 127, 127}; old = -128; end
        2: begin pat = '{-3, -4}; old = 5; end
        default: begin pat = '{-128, -128, 1}; old = 127; end
      endcase
      foreach (coefs[j]) begin
        coef = 9'(coefs[j]);
        run_iv(old, off);
        check({"R3 ", tag(coefs[j])}, off, blend(old, mean_of(), coefs[j]));
      end
    end
    coef = 9'h100;
    pat = '{-10, -10, -3};
    run_iv(0, off);
    check("R3 truncation toward zero", off, -7);

    // R3 sample in the closing cycle belongs to that interval
    fresh(0);
    repeat (3) cyc(0, 1, 0, 0, 0);
    cyc(64, 1, 1, 0, 0);
    idle(40);
    probe(off);
    check("R3 closing-cycle sample", off, 16);

    // R7 empty interval
    fresh(33);
    cyc(0, 0, 1, 0, 0);
    idle(40);
    probe(off);
    check("R7 empty interval", off, 33);

    // R8 count limit 15 with CNT_W=4
    pat = {};
    repeat (15) pat.push_back(10);
    repeat (5) pat.push_back(100);
    run_iv(0, off);
    check("R8 count limit", off, 10);

    // R9 host write while division runs
    fresh(0);
    repeat (4) cyc(50, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    idle(2);
    cyc(0, 0, 0, 1, -7);
    idle(40);
    probe(off);
    check("R9 write discards in-flight update", off, -7);

    fresh(0);
    repeat (4) cyc(50, 1, 0, 0, 0);
    cyc(0, 0, 1, 1, -9);
    idle(40);
    probe(off);
    check("R9 write in closing cycle", off, -9);

    // R10 second close during division is dropped
    fresh(0);
    repeat (4) cyc(20, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    idle(3);
    repeat (4) cyc(90, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    idle(40);
    probe(off);
    check("R10 busy interval dropped", off, 20);

    // R10 update lands within SUM_W+3 cycles
    fresh(0);
    repeat (2) cyc(40, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    idle(W + CW + 2);
    probe(off);
    check("R10 update latency bound", off, 40);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule